// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Automatic Request-to-Send

The block turns an asynchronous serial line into parallel characters. It samples the line at sixteen times the bit rate, using a one-cycle enable that comes from outside. It confirms each start bit at mid-bit, shifts in five to eight data bits with the least significant bit first, and can check a parity bit. It also checks the stop bit and recognises a break. Each character goes into a three-entry FIFO together with its framing, parity and break flags. A host pops characters from the FIFO head.

Two eight-bit mode registers share one write/read port. An internal pointer chooses which of the two an access reaches. The first mode register sets the character length, the parity handling, the error-status mode, the interrupt source and automatic control of the active-low request-to-send output. The second register is stored and can be read back. Single-cycle command strobes do the following: return the pointer to the first register, clear the error state, and drive request-to-send active or inactive.

Top module: `uart_rx_flow`

## Requirements
- R1: Reset and the `ptr_rst_i` strobe select mode register 1. Any write or read strobe that reaches register 1 moves the pointer to register 2. Accesses to register 2 leave the pointer there. `mode_rdata_o` shows the register that is currently selected, and both registers reset to 0x00.
- R2: Mode register 1 bits [1:0] give the number of data bits: 00=5, 01=6, 10=7, 11=8. Data bits arrive LSB first. Unused upper bits of `rx_data_o` read 0.
- R3: Mode register 1 bits [4:3] set parity handling: 00 = parity checked, 01 = forced level checked, 10 = no parity bit, 11 = wake-up mode. In wake-up mode the extra bit is received but never checked. Bit [2]=0 selects even parity (or a forced level of 0), and bit [2]=1 selects odd parity (or a forced level of 1). A mismatch sets PE for that character.
- R4: A falling edge starts a frame only if the line is still low on the 8th sample of 16. A start that is high again by then is discarded, and the receiver goes back to idle.
- R5: A stop bit sampled low sets FE for that character. The receiver waits for the line to return high before it accepts a new start bit.
- R6: A frame whose data, parity and stop bits are all zero stores one character of 0x00 with the break flag set and FE and PE clear.
- R7: The FIFO holds 3 characters. `rx_rdy_o` means it is not empty, and `ffull_o` means it is full. A character that arrives while the FIFO is full is dropped and sets `ovr_o`. `err_rst_i` clears `ovr_o`.
- R8: When mode register 1 bit [5]=0, FE, PE and break describe only the FIFO head. When bit [5]=1, they hold the OR of every character that has reached the head since the last `err_rst_i`.
- R9: Mode register 1 bit [6] selects the interrupt source: 0 uses `rx_rdy_o` and 1 uses `ffull_o`.
- R10: `rtsn_o` resets high. `rts_on_i` drives it low on the next cycle, and `rts_off_i` drives it high on the next cycle.
- R11: When mode register 1 bit [7]=1, a confirmed start bit while the FIFO is full drives `rtsn_o` high. It goes low again once a FIFO slot frees. When bit [7]=0, `rtsn_o` is left unchanged in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle enable at 16x the bit rate |
| rxd_i | input | 1 | Serial receive line |
| mode_wr_i | input | 1 | Write strobe for the mode register port |
| mode_rd_i | input | 1 | Read strobe for the mode register port (advances the pointer) |
| mode_wdata_i | input | 8 | Mode register write data |
| mode_rdata_o | output | 8 | Currently selected mode register |
| ptr_rst_i | input | 1 | Command: select mode register 1 |
| rts_on_i | input | 1 | Command: drive request-to-send active |
| rts_off_i | input | 1 | Command: drive request-to-send inactive |
| err_rst_i | input | 1 | Command: clear overrun and accumulated errors |
| rx_pop_i | input | 1 | Remove the FIFO head |
| rx_data_o | output | 8 | FIFO head character |
| rx_rdy_o | output | 1 | FIFO not empty |
| ffull_o | output | 1 | FIFO full |
| fe_o | output | 1 | Framing error status |
| pe_o | output | 1 | Parity error status |
| brk_o | output | 1 | Break status |
| ovr_o | output | 1 | Overrun flag |
| irq_o | output | 1 | Interrupt request |
| rtsn_o | output | 1 | Request-to-send, active low |

## Verification
A character appears at the FIFO head within a few clocks of the mid-stop sample. That sample falls half a bit time into the stop bit, behind two synchroniser flops. The bench therefore holds each bit for a full 32 clocks and checks the outputs only after the whole stop bit has passed. Pops, command strobes and mode writes take effect at the next clock edge, and they are checked on the falling edge straight after it. An automatic request-to-send negation follows the 8th start sample, so it is checked at the end of the start bit. The reassertion trails the pop by two edges and is checked three clocks later.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [1:0] {
    PAR_CHECK = 2'b00,
    PAR_FORCE = 2'b01,
    PAR_NONE  = 2'b10,
    PAR_WAKE  = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic       auto_rts;
    logic       irq_full;
    logic       blk_err;
    logic [1:0] par_mode;
    logic       par_odd;
    logic [1:0] len;
  } mode1_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              fe;
    logic              pe;
    logic              brk;
  } rx_char_t;
endpackage

// File: rtl/uart_rx_mode_regs.sv
module uart_rx_mode_regs
  import uart_rx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [7:0]  wdata_i,
  input  logic        ptr_rst_i,
  output logic [7:0]  rdata_o,
  output mode1_t      mode1_o
);
  logic       sel2_q;
  logic [7:0] m1_q, m2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel2_q <= 1'b0;
      m1_q   <= '0;
      m2_q   <= '0;
    end else begin
      if (wr_i) begin
        if (sel2_q) m2_q <= wdata_i;
        else        m1_q <= wdata_i;
      end
      if (ptr_rst_i)                     sel2_q <= 1'b0;
      else if ((wr_i || rd_i) && !sel2_q) sel2_q <= 1'b1;
    end
  end

  assign rdata_o = sel2_q ? m2_q : m1_q;
  assign mode1_o = mode1_t'(m1_q);

  a_r1_ptr_home: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_rst_i |=> !sel2_q);
  a_r1_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel2_q && (wr_i || rd_i) && !ptr_rst_i) |=> sel2_q);
  a_r1_m2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel2_q && !ptr_rst_i) |=> sel2_q);
  a_r1_m1_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel2_q && wr_i) |=> $stable(m1_q));
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic [1:0] len_i,
  input  logic [1:0] par_mode_i,
  input  logic       par_odd_i,
  output logic       start_ok_o,
  output logic       push_o,
  output rx_char_t   char_o
);
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} st_e;

  st_e               st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [2:0]        bit_q;
  logic [DATA_W-1:0] shift_q;
  logic              par_q, nz_q;
  logic [1:0]        sync_q;
  logic              rxd_s, smp, has_par, chk_par, exp_par, brk;
  logic [2:0]        last_bit;

  assign rxd_s    = sync_q[1];
  assign smp      = tick_i && (cnt_q == LAST);
  assign last_bit = {1'b0, len_i} + 3'd4;
  assign has_par  = par_mode_i != PAR_NONE;
  assign chk_par  = (par_mode_i == PAR_CHECK) || (par_mode_i == PAR_FORCE);
  assign exp_par  = (par_mode_i == PAR_FORCE) ? par_odd_i : ((^shift_q) ^ par_odd_i);
  assign brk      = !nz_q && !rxd_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q     <= 2'b11;
      st_q       <= S_IDLE;
      cnt_q      <= '0;
      bit_q      <= '0;
      shift_q    <= '0;
      par_q      <= 1'b0;
      nz_q       <= 1'b0;
      start_ok_o <= 1'b0;
      push_o     <= 1'b0;
      char_o     <= '0;
    end else begin
      sync_q     <= {sync_q[0], rxd_i};
      start_ok_o <= 1'b0;
      push_o     <= 1'b0;
      if (tick_i && st_q inside {S_DATA, S_PAR, S_STOP}) cnt_q <= smp ? '0 : cnt_q + 1'b1;
      case (st_q)
        S_IDLE: if (tick_i && !rxd_s) begin
          st_q  <= S_START;
          cnt_q <= CNT_W'(1);
        end
        S_START: if (tick_i) begin
          if (cnt_q == MID) begin
            if (rxd_s) st_q <= S_IDLE;   // false start
            else begin
              st_q       <= S_DATA;
              cnt_q      <= '0;
              bit_q      <= '0;
              shift_q    <= '0;
              nz_q       <= 1'b0;
              start_ok_o <= 1'b1;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_DATA: if (smp) begin
          shift_q[bit_q] <= rxd_s;
          nz_q           <= nz_q | rxd_s;
          if (bit_q == last_bit) st_q <= has_par ? S_PAR : S_STOP;
          else                   bit_q <= bit_q + 1'b1;
        end
        S_PAR: if (smp) begin
          par_q <= rxd_s;
          nz_q  <= nz_q | rxd_s;
          st_q  <= S_STOP;
        end
        S_STOP: if (smp) begin
          push_o      <= 1'b1;
          char_o.data <= shift_q;
          char_o.brk  <= brk;
          char_o.fe   <= !rxd_s && nz_q;
          char_o.pe   <= chk_par && (par_q != exp_par) && !brk;
          st_q        <= rxd_s ? S_IDLE : S_HOLD;
        end
        S_HOLD: if (tick_i && rxd_s) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  a_r4_false_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_START && tick_i && cnt_q == MID && rxd_s) |=> (st_q == S_IDLE && !start_ok_o));
  a_r5_hold_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_HOLD && !rxd_s) |=> st_q == S_HOLD);
  a_r6_break_char: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && char_o.brk) |-> (char_o.data == '0 && !char_o.fe && !char_o.pe));
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 3
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  rx_char_t wdata_i,
  input  logic     rd_i,
  input  logic     clr_ovr_i,
  output rx_char_t head_o,
  output logic     empty_o,
  output logic     full_o,
  output logic     ovr_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  rx_char_t        mem_q [DEPTH];
  logic [AW-1:0]   wp_q, rp_q;
  logic [CW-1:0]   cnt_q;
  logic            do_wr, do_rd;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = cnt_q == '0;
  assign full_o  = cnt_q == CW'(DEPTH);
  assign do_wr   = wr_i && !full_o;
  assign do_rd   = rd_i && !empty_o;
  assign head_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) if (do_wr) mem_q[wp_q] <= wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovr_o <= 1'b0;
    end else begin
      if (do_wr) wp_q <= nxt(wp_q);
      if (do_rd) rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + CW'(do_wr) - CW'(do_rd);
      if (clr_ovr_i)          ovr_o <= 1'b0;
      else if (wr_i && full_o) ovr_o <= 1'b1;
    end
  end

  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r7_drop_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_o && !rd_i && !clr_ovr_i) |=> (full_o && ovr_o));
  a_r7_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && empty_o && !wr_i) |=> empty_o);
endmodule

// File: rtl/uart_rx_flow.sv
module uart_rx_flow
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS        = 16,
  parameter int unsigned FIFO_DEPTH = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       baud_tick_i,
  input  logic       rxd_i,
  input  logic       mode_wr_i,
  input  logic       mode_rd_i,
  input  logic [7:0] mode_wdata_i,
  output logic [7:0] mode_rdata_o,
  input  logic       ptr_rst_i,
  input  logic       rts_on_i,
  input  logic       rts_off_i,
  input  logic       err_rst_i,
  input  logic       rx_pop_i,
  output logic [7:0] rx_data_o,
  output logic       rx_rdy_o,
  output logic       ffull_o,
  output logic       fe_o,
  output logic       pe_o,
  output logic       brk_o,
  output logic       ovr_o,
  output logic       irq_o,
  output logic       rtsn_o
);
  mode1_t   m1;
  rx_char_t rx_char, head;
  logic     push, start_ok, empty, do_pop, seen_q, auto_q;
  logic [2:0] acc_q, head_st, fresh_st, stat;

  uart_rx_mode_regs u_regs (
    .clk_i, .rst_ni,
    .wr_i(mode_wr_i), .rd_i(mode_rd_i), .wdata_i(mode_wdata_i),
    .ptr_rst_i, .rdata_o(mode_rdata_o), .mode1_o(m1)
  );

  uart_rx_frame #(.OVS(OVS)) u_frame (
    .clk_i, .rst_ni, .tick_i(baud_tick_i), .rxd_i,
    .len_i(m1.len), .par_mode_i(m1.par_mode), .par_odd_i(m1.par_odd),
    .start_ok_o(start_ok), .push_o(push), .char_o(rx_char)
  );

  uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .wr_i(push), .wdata_i(rx_char), .rd_i(rx_pop_i),
    .clr_ovr_i(err_rst_i), .head_o(head), .empty_o(empty),
    .full_o(ffull_o), .ovr_o
  );

  assign rx_rdy_o  = !empty;
  assign rx_data_o = head.data;
  assign do_pop    = rx_pop_i && rx_rdy_o;
  assign head_st   = rx_rdy_o ? {head.fe, head.pe, head.brk} : 3'b000;
  assign fresh_st  = seen_q ? 3'b000 : head_st;
  assign stat      = m1.blk_err ? (acc_q | fresh_st) : head_st;
  assign {fe_o, pe_o, brk_o} = stat;
  assign irq_o     = m1.irq_full ? ffull_o : rx_rdy_o;

  // seen_q: current head already folded into acc_q (or excluded by err reset)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      seen_q <= 1'b0;
    end else if (err_rst_i) begin
      acc_q  <= '0;
      seen_q <= rx_rdy_o && !do_pop;
    end else begin
      acc_q  <= acc_q | fresh_st;
      seen_q <= rx_rdy_o && !do_pop;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rtsn_o <= 1'b1;
      auto_q <= 1'b0;
    end else if (rts_on_i) begin
      rtsn_o <= 1'b0;
      auto_q <= 1'b0;
    end else if (rts_off_i) begin
      rtsn_o <= 1'b1;
      auto_q <= 1'b0;
    end else if (m1.auto_rts && start_ok && ffull_o) begin
      rtsn_o <= 1'b1;
      auto_q <= 1'b1;
    end else if (auto_q && !ffull_o) begin
      rtsn_o <= 1'b0;
      auto_q <= 1'b0;
    end
  end

  a_r10_rts_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rts_on_i |=> !rtsn_o);
  a_r10_rts_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rts_off_i && !rts_on_i) |=> rtsn_o);
  a_r11_auto_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m1.auto_rts && start_ok && ffull_o && !rts_on_i && !rts_off_i) |=> rtsn_o);
  a_r11_manual_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!m1.auto_rts && !auto_q && !rts_on_i && !rts_off_i) |=> $stable(rtsn_o));
  a_r9_irq_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_rdy_o |-> !irq_o);
  a_r8_char_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!m1.blk_err && !rx_rdy_o) |-> (stat == 3'b000));
endmodule

// File: tb/tb_uart_rx_flow.sv
module tb_uart_rx_flow;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rxd = 1'b1;
  logic mode_wr = 0, mode_rd = 0, ptr_rst = 0, rts_on = 0, rts_off = 0, err_rst = 0, pop = 0;
  logic [7:0] wdata = '0, rdata, rx_data;
  logic rx_rdy, ffull, fe, pe, brk, ovr, irq, rtsn;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  uart_rx_flow dut (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .rxd_i(rxd),
    .mode_wr_i(mode_wr), .mode_rd_i(mode_rd), .mode_wdata_i(wdata), .mode_rdata_o(rdata),
    .ptr_rst_i(ptr_rst), .rts_on_i(rts_on), .rts_off_i(rts_off), .err_rst_i(err_rst),
    .rx_pop_i(pop), .rx_data_o(rx_data), .rx_rdy_o(rx_rdy), .ffull_o(ffull),
    .fe_o(fe), .pe_o(pe), .brk_o(brk), .ovr_o(ovr), .irq_o(irq), .rtsn_o(rtsn)
  );

  initial forever begin @(negedge clk); tick = ~tick; end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n); repeat (n) @(negedge clk); endtask

  // 0 ptr_rst, 1 rts_on, 2 rts_off, 3 err_rst, 4 pop, 5 mode read
  task automatic strobe(input int which);
    case (which)
      0: ptr_rst = 1; 1: rts_on = 1; 2: rts_off = 1; 3: err_rst = 1; 4: pop = 1; default: mode_rd = 1;
    endcase
    @(negedge clk);
    {ptr_rst, rts_on, rts_off, err_rst, pop, mode_rd} = '0;
  endtask

  task automatic wr_mode(input logic [7:0] v);
    wdata = v; mode_wr = 1; @(negedge clk); mode_wr = 0;
  endtask

  task automatic set_m1(input logic [7:0] v); strobe(0); wr_mode(v); endtask

  task automatic bit_out(input logic b); rxd = b; clks(32); endtask

  task automatic send(input logic [7:0] d, input int n, input bit par_en, input bit par_b, input bit stop_b);
    bit_out(1'b0);
    for (int i = 0; i < n; i++) bit_out(d[i]);
    if (par_en) bit_out(par_b);
    bit_out(stop_b);
    rxd = 1'b1; clks(8);
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) if (rx_rdy) strobe(4);
    strobe(3);
  endtask

  task automatic t_reset();
    check("R7 reset rdy", rx_rdy, 0); check("R7 reset full", ffull, 0);
    check("R10 reset rtsn", rtsn, 1); check("R9 reset irq", irq, 0);
    check("R1 reset m1", rdata, 8'h00); check("R7 reset ovr", ovr, 0);
  endtask

  task automatic t_pointer();
    strobe(0); wr_mode(8'h13); wr_mode(8'hA0);
    check("R1 m2 after m1", rdata, 8'hA0);
    wr_mode(8'hB0);
    check("R1 m2 sticky", rdata, 8'hB0);
    strobe(0);
    check("R1 ptr reset", rdata, 8'h13);
    strobe(5);
    check("R1 read advance", rdata, 8'hB0);
    strobe(5);
    check("R1 read stays", rdata, 8'hB0);
  endtask

  task automatic t_8n1();
    set_m1(8'h13);
    send(8'hA5, 8, 0, 0, 1);
    check("R2 8bit data", rx_data, 8'hA5);
    check("R7 rdy", rx_rdy, 1);
    check("R3 no pe", pe, 0); check("R5 no fe", fe, 0);
    strobe(4);
    check("R7 empty after pop", rx_rdy, 0);
  endtask

  task automatic t_len5();
    set_m1(8'h10);
    send(8'hF5, 5, 0, 0, 1);
    check("R2 5bit data", rx_data, 8'h15);
    drain();
  endtask

  task automatic t_parity();
    set_m1(8'h02);
    send(8'h35, 7, 1, ^(7'h35), 1);
    check("R3 even ok data", rx_data, 8'h35); check("R3 even ok", pe, 0);
    strobe(4);
    send(8'h35, 7, 1, ~^(7'h35), 1);
    check("R3 even bad", pe, 1); strobe(4);
    set_m1(8'h06);
    send(8'h35, 7, 1, ~^(7'h35), 1);
    check("R3 odd ok", pe, 0); strobe(4);
    set_m1(8'h0D);
    send(8'h2A, 6, 1, 0, 1);
    check("R3 force mismatch", pe, 1); strobe(4);
    send(8'h2A, 6, 1, 1, 1);
    check("R3 force match", pe, 0); strobe(4);
    set_m1(8'h1B);
    send(8'h5C, 8, 1, 0, 1);
    check("R3 wake unchecked", pe, 0);
    check("R3 wake data", rx_data, 8'h5C);
    drain();
  endtask

  task automatic t_frame_break();
    set_m1(8'h13);
    send(8'h5A, 8, 0, 0, 0);
    check("R5 fe set", fe, 1); check("R6 not break", brk, 0);
    check("R5 fe data", rx_data, 8'h5A);
    send(8'h3C, 8, 0, 0, 1);
    strobe(4);
    check("R5 next char", rx_data, 8'h3C); check("R5 next fe", fe, 0);
    strobe(4);
    send(8'h00, 8, 0, 0, 0);
    check("R6 brk", brk, 1); check("R6 brk data", rx_data, 8'h00); check("R6 brk fe", fe, 0);
    drain();
  endtask

  task automatic t_false_start();
    rxd = 1'b0; clks(12); rxd = 1'b1; clks(64);
    check("R4 false start", rx_rdy, 0);
    send(8'h81, 8, 0, 0, 1);
    check("R4 recovers", rx_data, 8'h81);
    drain();
  endtask

  task automatic t_fifo();
    send(8'h11, 8, 0, 0, 1); send(8'h22, 8, 0, 0, 1);
    check("R7 not full at 2", ffull, 0);
    send(8'h33, 8, 0, 0, 1);
    check("R7 full", ffull, 1); check("R9 irq rdy", irq, 1); check("R7 no ovr yet", ovr, 0);
    send(8'h44, 8, 0, 0, 1);
    check("R7 overrun", ovr, 1);
    check("R7 head 1", rx_data, 8'h11); strobe(4);
    check("R7 head 2", rx_data, 8'h22); strobe(4);
    check("R7 head 3", rx_data, 8'h33); strobe(4);
    check("R7 dropped", rx_rdy, 0);
    strobe(3);
    check("R7 ovr clear", ovr, 0);
  endtask

  task automatic t_irq();
    set_m1(8'h53);
    send(8'h01, 8, 0, 0, 1);
    check("R9 irq full sel", irq, 0);
    send(8'h02, 8, 0, 0, 1); send(8'h03, 8, 0, 0, 1);
    check("R9 irq full", irq, 1);
    drain();
  endtask

  task automatic t_rts();
    set_m1(8'h13);
    strobe(1);
    check("R10 rts on", rtsn, 0);
    send(8'h01, 8, 0, 0, 1); send(8'h02, 8, 0, 0, 1); send(8'h03, 8, 0, 0, 1);
    send(8'h04, 8, 0, 0, 1);
    check("R11 manual kept", rtsn, 0);
    drain();
    set_m1(8'h93);
    send(8'h01, 8, 0, 0, 1); send(8'h02, 8, 0, 0, 1); send(8'h03, 8, 0, 0, 1);
    check("R11 rts low at full", rtsn, 0);
    bit_out(1'b0);
    check("R11 auto negate", rtsn, 1);
    for (int i = 0; i < 8; i++) bit_out(1'b1);
    bit_out(1'b1); clks(8);
    check("R11 stays negated", rtsn, 1);
    strobe(4); clks(3);
    check("R11 reassert", rtsn, 0);
    strobe(2);
    check("R10 rts off", rtsn, 1);
    drain();
  endtask

  task automatic t_block();
    set_m1(8'h13);
    send(8'h55, 8, 0, 0, 0); send(8'h66, 8, 0, 0, 1);
    strobe(4);
    check("R8 char mode head", fe, 0);
    drain();
    set_m1(8'h33);
    send(8'h55, 8, 0, 0, 0); send(8'h66, 8, 0, 0, 1);
    check("R8 block first", fe, 1);
    strobe(4);
    check("R8 block sticky", fe, 1);
    check("R8 block head", rx_data, 8'h66);
    strobe(3);
    check("R8 block cleared", fe, 0);
    drain();
  endtask

  initial begin
    clks(3); rst_n = 1'b1; clks(2);
    t_reset(); t_pointer(); t_8n1(); t_len5(); t_parity(); t_frame_break();
    t_false_start(); t_fifo(); t_irq(); t_rts(); t_block();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule